// File: doc/BRIEF.md
# Boot Mode and Program Map Controller

This block decides how the chip comes out of reset. It samples three configuration inputs on each clock edge where reset is held: a flash-unlocked status, an external-boot strap and an external-memory-width strap. From them it sets two mode bits. MB records whether flash was open at reset. MA selects the external program-space map. The block also latches the width strap. From this held state it drives four things: the program-space map select, the external address width, the enable for the on-chip debug port, and a request that turns four general-purpose pins into address bits 19 to 16. It also presents one of two reset-vector addresses, which are set by parameters.

Software sees the mode bits in a single register, which it can read and write. Its write rules come from the state latched at reset. MB cannot be written. MA can be written only when MB was set at reset. A reset with flash secured and the external-boot strap high is not allowed, so it falls back to internal mode with both bits clear.

Top module: `boot_mode_ctrl`

## Requirements
- R1: Reset is synchronous and active low. At each rising edge of `clk` with `rst_n` low, MB takes `flash_unlocked` and MA takes `ext_boot_pin`, except as R2 states.
- R2: If `flash_unlocked` is 0 and `ext_boot_pin` is 1 at the reset edge, both MB and MA become 0 (internal boot).
- R3: After reset, MB holds its value whatever `flash_unlocked` does, until the next reset edge.
- R4: Bit 1 of `wr_data` is ignored on a write, so MB does not change.
- R5: With MB=1, a write with `wr_en` high loads bit 0 of `wr_data` into MA at that edge. `pmap_ext` equals MA.
- R6: With MB=0, MA stays 0 and `pmap_ext` stays 0 whatever is written.
- R7: `debug_en` and `ext_pspace_ok` both equal MB.
- R8: `addr_hi_en` is 1 only when, at reset, flash was unlocked, `ext_boot_pin` was 1 and `ext_mem_mode_pin` was 1. `addr_lines` is then NARROW_LINES+4 (default 20), and otherwise NARROW_LINES (default 16). Neither changes when software writes MA.
- R9: `rd_data` bit 0 is MA, bit 1 is MB, bit 2 is `ext_mem_mode_pin` as latched at reset, and all higher bits are 0. Bit 2 is read-only and does not follow the pin after reset.
- R10: `reset_vec` is RST_VEC_WIDE (default 24'h190000) when the latched width strap is 1, and otherwise RST_VEC_STD (default 24'h000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flash_unlocked | input | 1 | 1 when flash is not secured |
| ext_boot_pin | input | 1 | External-boot strap |
| ext_mem_mode_pin | input | 1 | External address width strap |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | DW | Write data (bit 0 = MA) |
| rd_data | output | DW | Mode register read value |
| pmap_ext | output | 1 | 1 selects the external program-space map |
| ext_pspace_ok | output | 1 | External program space permitted |
| debug_en | output | 1 | On-chip debug port enable |
| addr_hi_en | output | 1 | Assigns four GPIO pins as address bits 19..16 |
| addr_lines | output | 5 | Number of external address lines in use |
| reset_vec | output | VW | Reset vector address |

## Verification
The assertions assume that the straps and `flash_unlocked` are settled at every reset edge, that `wr_en` is meaningful only while `rst_n` is high, and that a write never arrives in the same cycle as a reset. The bench sets the straps and releases reset only on falling edges. It applies writes only after reset has been released, and it toggles the strap inputs after reset only to show that they have no effect.

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl #(
  parameter int DW = 16,
  parameter int VW = 24,
  parameter int NARROW_LINES = 16,
  parameter logic [VW-1:0] RST_VEC_STD  = 24'h000000,
  parameter logic [VW-1:0] RST_VEC_WIDE = 24'h190000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flash_unlocked,
  input  logic          ext_boot_pin,
  input  logic          ext_mem_mode_pin,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          pmap_ext,
  output logic          ext_pspace_ok,
  output logic          debug_en,
  output logic          addr_hi_en,
  output logic [4:0]    addr_lines,
  output logic [VW-1:0] reset_vec
);
  localparam logic [4:0] LINES_NARROW = 5'(NARROW_LINES);
  localparam logic [4:0] LINES_WIDE   = 5'(NARROW_LINES + 4);

  logic mb_q, ma_q, emi_q, xboot_q;
  logic unused_wr;

  assign unused_wr = ^wr_data[DW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_q    <= flash_unlocked;
      ma_q    <= flash_unlocked & ext_boot_pin;
      xboot_q <= flash_unlocked & ext_boot_pin;
      emi_q   <= ext_mem_mode_pin;
    end else if (wr_en && mb_q) begin
      ma_q <= wr_data[0];
    end
  end

  assign pmap_ext      = mb_q & ma_q;
  assign ext_pspace_ok = mb_q;
  assign debug_en      = mb_q;
  assign addr_hi_en    = xboot_q & emi_q;
  assign addr_lines    = addr_hi_en ? LINES_WIDE : LINES_NARROW;
  assign reset_vec     = emi_q ? RST_VEC_WIDE : RST_VEC_STD;
  assign rd_data       = {{(DW-3){1'b0}}, emi_q, mb_q, ma_q};

  assert_secured_extboot_R2: assert property (@(posedge clk)
    (!rst_n && !flash_unlocked) |=> (rd_data[1:0] == 2'b00));

  assert_mb_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(rd_data[1]));

  assert_ma_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[1]) |=> (pmap_ext == $past(wr_data[0])));

  assert_ma_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> (!rd_data[0] && !pmap_ext));

  assert_wide_needs_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hi_en |-> (debug_en && rd_data[2]));

  assert_emi_status_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(rd_data[2]));
endmodule

// File: tb/boot_mode_ctrl_test.sv
module boot_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flash_unlocked = 1'b0, ext_boot_pin = 1'b0, ext_mem_mode_pin = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic pmap_ext, ext_pspace_ok, debug_en, addr_hi_en;
  logic [4:0] addr_lines;
  logic [23:0] reset_vec;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  boot_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .flash_unlocked(flash_unlocked),
    .ext_boot_pin(ext_boot_pin), .ext_mem_mode_pin(ext_mem_mode_pin),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pmap_ext(pmap_ext),
    .ext_pspace_ok(ext_pspace_ok), .debug_en(debug_en), .addr_hi_en(addr_hi_en),
    .addr_lines(addr_lines), .reset_vec(reset_vec)
  );

  // {unlocked, ext_boot, emi, exp_mb, exp_ma, exp_wide}
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b001_000, 6'b010_000, 6'b011_000,
    6'b100_100, 6'b101_100, 6'b110_110, 6'b111_111
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic u, logic e, logic m);
    @(negedge clk);
    flash_unlocked = u; ext_boot_pin = e; ext_mem_mode_pin = m; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      logic mb, ma, wide, emi;
      mb = VEC[i][2]; ma = VEC[i][1]; wide = VEC[i][0]; emi = VEC[i][3];
      do_reset(VEC[i][5], VEC[i][4], VEC[i][3]);
      chk("R1 R2 mode bits", rd_data[1:0], {mb, ma});
      chk("R9 read layout", rd_data, {13'b0, emi, mb, ma});
      chk("R5 pmap", pmap_ext, ma);
      chk("R7 debug_en", debug_en, mb);
      chk("R7 ext_pspace_ok", ext_pspace_ok, mb);
      chk("R8 addr_hi_en", addr_hi_en, wide);
      chk("R8 addr_lines", addr_lines, wide ? 20 : 16);
      chk("R10 reset_vec", reset_vec, emi ? 24'h190000 : 24'h000000);
    end

    // R3 and R9: strap changes after reset have no effect
    do_reset(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    flash_unlocked = 1'b0; ext_boot_pin = 1'b0; ext_mem_mode_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 mb held", rd_data[1], 1'b1);
    chk("R9 emi status held", rd_data[2], 1'b1);
    chk("R10 vec held", reset_vec, 24'h190000);

    // R5: writes to MA with MB=1, and R8 width fixed
    do_write(16'h0000);
    chk("R5 ma cleared", rd_data[0], 1'b0);
    chk("R5 pmap internal", pmap_ext, 1'b0);
    chk("R8 width unchanged by MA", addr_lines, 20);
    // R4: write attempts to clear MB
    do_write(16'h0001);
    chk("R4 mb unwritable", rd_data[1], 1'b1);
    chk("R5 ma set", pmap_ext, 1'b1);
    chk("R9 bit2 read-only", rd_data[2], 1'b1);
    chk("R8 hi_en unchanged by MA", addr_hi_en, 1'b1);

    // R6: MB=0 locks MA; R4: writing MB bit cannot set it
    do_reset(1'b0, 1'b0, 1'b0);
    do_write(16'hFFFF);
    chk("R6 ma locked", rd_data[0], 1'b0);
    chk("R6 pmap locked", pmap_ext, 1'b0);
    chk("R4 mb stays clear", rd_data[1], 1'b0);
    chk("R7 debug off", debug_en, 1'b0);
    flash_unlocked = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 mb not following status", rd_data[1], 1'b0);

    // R2: secured with ext boot and emi high
    do_reset(1'b0, 1'b1, 1'b1);
    chk("R2 forced internal", rd_data[1:0], 2'b00);
    chk("R8 narrow when secured", addr_lines, 16);
    do_write(16'h0001);
    chk("R6 ma locked after R2", pmap_ext, 1'b0);

    // R1: internal boot unlocked, MA writable to 1 then back
    do_reset(1'b1, 1'b0, 1'b0);
    chk("R1 internal unlocked", rd_data[1:0], 2'b10);
    do_write(16'h0003);
    chk("R5 ma to ext map", pmap_ext, 1'b1);
    chk("R8 no hi pins internal boot", addr_hi_en, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule